// File: doc/BRIEF.md
# SD Host Vendor Register Bank

This block is a memory-mapped register bank placed in front of a standard SD host slot register set. A 32-bit register-bus slave decodes a 4 KiB window. The lower part of the window holds a small set of vendor host registers. Every access at or above offset 0x200 is passed to a separate slot-register port with the base subtracted. The slot's interrupt line goes straight through to the block's interrupt output.

Three vendor registers behave differently from plain storage. A PHY access port echoes an acknowledge bit whenever a read or write request bit is written. An eMMC control word drops its tune request bit on every write. A general-information word is read-only, and setting its lowest bit starts a software reset. That reset clears the whole bank and sends a one-cycle cold-reset pulse to the attached slot. Software writes a request and reads the acknowledge back at once. It uses the reset bit to return the bank and the slot to their power-on state.

Top module: `sd_vendor_regbank`

## Requirements
- R1: After reset, offset 0x00 reads 0x00010000 and every other vendor offset below 0x200 reads 0.
- R2: A write to offset 0x10 stores the word with bit 26 set to 1 when bit 24 or bit 25 of the written word is 1, and set to 0 otherwise. All other bits are kept as written.
- R3: A write to offset 0x18 stores the word with bit 15 cleared and every other bit kept.
- R4: A write to any other vendor offset in 0x04..0x1FC stores the word unchanged, and a later read returns it.
- R5: A write to offset 0x00 with bit 0 set completes normally, with rdata 0 and no error. During its response cycle it raises slot_rst for exactly one cycle. The next access sees every vendor register at its R1 value.
- R6: A write to offset 0x00 with bit 0 clear has no effect: offset 0x00 still reads 0x00010000, other registers keep their values, and slot_rst stays low.
- R7: A valid access to offsets 0x200..0xFFF is forwarded on the slot port with slot_addr = offset - 0x200 and the same write flag and wdata. A forwarded read returns slot_rdata on bus_rdata.
- R8: A forwarded access holds slot_valid, slot_addr and slot_wdata stable until slot_ready. bus_ready follows one cycle after the cycle in which slot_valid and slot_ready are both high.
- R9: A vendor or rejected access raises bus_ready in the cycle after bus_valid is sampled. bus_ready is always a single-cycle pulse, and write responses carry rdata 0.
- R10: An access whose address is not a multiple of 4, or whose bus_size is not 2 (the field holds log2 of the byte count, so 2 means 32 bits), is answered with bus_err = 1 and rdata 0. It changes no register and is not forwarded.
- R11: irq always equals slot_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_size | input | 2 | log2 of the access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Rejected access, valid with bus_ready |
| slot_valid | output | 1 | Forwarded request |
| slot_write | output | 1 | Forwarded write flag |
| slot_addr | output | 12 | Offset within the slot register set |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32 | Slot read data |
| slot_ready | input | 1 | Slot completion |
| slot_rst | output | 1 | One-cycle cold reset to the slot |
| slot_irq | input | 1 | Slot interrupt |
| irq | output | 1 | Block interrupt |

## Verification
The hardest situation to reach is the software reset. Its effect appears one cycle after the triggering write, and that cycle is the very cycle in which the bus response is delivered. The stimulus first loads distinct words into the PHY port, the tune register and a plain register. It then writes the reset bit and watches slot_rst count exactly one pulse. The bench issues the next read immediately after the response, so a clear that lands a cycle late would show up as stale data. The slot responder also stretches slot_ready by a programmable delay so that the wait path and the latency arithmetic are both exercised.

// File: rtl/sdvb_pkg.sv
package sdvb_pkg;

   localparam int unsigned DATA_W      = 32;
   localparam int unsigned SWR_BIT     = 0;
   localparam int unsigned TUNE_BIT    = 15;
   localparam int unsigned PHY_WR_BIT  = 24;
   localparam int unsigned PHY_RD_BIT  = 25;
   localparam int unsigned PHY_ACK_BIT = 26;
   localparam logic [1:0]  SIZE_WORD   = 2'd2;

   typedef logic [DATA_W-1:0] word_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SLOT = 2'd1,
      ST_RESP = 2'd2
   } bus_state_e;

   typedef enum logic [1:0] {
      REG_PLAIN = 2'd0,
      REG_PHY   = 2'd1,
      REG_TUNE  = 2'd2
   } reg_kind_e;

   // Shapes a written word according to the kind of register it lands in.
   function automatic word_t shape_write(reg_kind_e kind, word_t w);
      word_t r;
      r = w;
      case (kind)
         REG_PHY:  r[PHY_ACK_BIT] = w[PHY_WR_BIT] | w[PHY_RD_BIT];
         REG_TUNE: r[TUNE_BIT]    = 1'b0;
         default:  r = w;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sdvb_decode.sv
module sdvb_decode
   import sdvb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned SLOT_BASE = 'h200,
   parameter int unsigned VIDX_W    = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic              is_bad,
   output logic              is_slot,
   output logic [VIDX_W-1:0] word_idx,
   output logic [ADDR_W-1:0] slot_ofs
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SLOT_BASE);

   generate
      if (VIDX_W + 2 > ADDR_W) begin : g_bad_idx
         $error("sdvb_decode: word index does not fit the address");
      end
   endgenerate

   always_comb begin
      is_bad   = (addr[1:0] != 2'b00) || (size != SIZE_WORD);
      is_slot  = (addr >= BASE_A);
      word_idx = addr[VIDX_W+1:2];
      slot_ofs = addr - BASE_A;
   end

endmodule

// File: rtl/sdvb_vendor_bank.sv
module sdvb_vendor_bank
   import sdvb_pkg::*;
#(
   parameter int unsigned VEND_WORDS = 128,
   parameter int unsigned VIDX_W     = 7,
   parameter word_t       INFO_RESET = 32'h0001_0000,
   parameter int unsigned INFO_IDX   = 0,
   parameter int unsigned PHY_IDX    = 4,
   parameter int unsigned TUNE_IDX   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [VIDX_W-1:0] widx,
   input  word_t             wdata,
   input  logic [VIDX_W-1:0] ridx,
   output word_t             rdata,
   output logic              swr_pulse
);

   word_t words [VEND_WORDS];
   logic  swr_hit;
   logic  swr_q;

   generate
      if (INFO_IDX == PHY_IDX || INFO_IDX == TUNE_IDX || PHY_IDX == TUNE_IDX) begin : g_bad_map
         $error("sdvb_vendor_bank: special registers overlap");
      end
      if (INFO_IDX >= VEND_WORDS || PHY_IDX >= VEND_WORDS || TUNE_IDX >= VEND_WORDS) begin : g_bad_range
         $error("sdvb_vendor_bank: special register outside the bank");
      end
   endgenerate

   // Software reset request: a write to the info word with its reset bit set.
   assign swr_hit = we && (widx == VIDX_W'(INFO_IDX)) && wdata[SWR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) swr_q <= 1'b0;
      else        swr_q <= swr_hit;
   end

   assign swr_pulse = swr_q;

   generate
      for (genvar gi = 0; gi < VEND_WORDS; gi++) begin : g_word
         if (gi == INFO_IDX) begin : g_info
            // Read-only: no written bit ever changes this word.
            assign words[gi] = INFO_RESET;
         end else begin : g_store
            localparam reg_kind_e KIND = (gi == PHY_IDX)  ? REG_PHY  :
                                         (gi == TUNE_IDX) ? REG_TUNE : REG_PLAIN;
            word_t q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                               q <= '0;
               else if (swr_q)                           q <= '0;
               else if (we && widx == VIDX_W'(gi))       q <= shape_write(KIND, wdata);
            end
            assign words[gi] = q;
         end
      end
   endgenerate

   assign rdata = words[ridx];

   AST_PHY_ACK_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      words[PHY_IDX][PHY_ACK_BIT] == (words[PHY_IDX][PHY_WR_BIT] | words[PHY_IDX][PHY_RD_BIT])); // R2
   AST_TUNE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      words[TUNE_IDX][TUNE_BIT] == 1'b0); // R3
   AST_SWR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      swr_q |=> !swr_q); // R5
   AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      swr_q |=> (words[PHY_IDX] == '0 && words[TUNE_IDX] == '0)); // R5
   AST_INFO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      words[INFO_IDX] == INFO_RESET); // R6

endmodule

// File: rtl/sdvb_bus_fsm.sv
module sdvb_bus_fsm
   import sdvb_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  word_t             bus_wdata,
   input  logic              dec_bad,
   input  logic              dec_slot,
   input  logic [ADDR_W-1:0] dec_slot_ofs,
   input  word_t             bank_rdata,
   output logic              bank_we,
   output logic              bus_ready,
   output word_t             bus_rdata,
   output logic              bus_err,
   output logic              slot_valid,
   output logic              slot_write,
   output logic [ADDR_W-1:0] slot_addr,
   output word_t             slot_wdata,
   input  word_t             slot_rdata,
   input  logic              slot_ready
);

   bus_state_e        state_q;
   word_t             rdata_q;
   logic              err_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   word_t             wdata_q;

   assign bank_we = (state_q == ST_IDLE) && bus_valid && !dec_bad && !dec_slot && bus_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rdata_q <= '0;
         err_q   <= 1'b0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (bus_valid) begin
                  if (dec_bad) begin
                     err_q   <= 1'b1;
                     rdata_q <= '0;
                     state_q <= ST_RESP;
                  end else if (dec_slot) begin
                     err_q   <= 1'b0;
                     wr_q    <= bus_write;
                     addr_q  <= dec_slot_ofs;
                     wdata_q <= bus_wdata;
                     state_q <= ST_SLOT;
                  end else begin
                     err_q   <= 1'b0;
                     rdata_q <= bus_write ? '0 : bank_rdata;
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_SLOT: begin
               if (slot_ready) begin
                  rdata_q <= wr_q ? '0 : slot_rdata;
                  state_q <= ST_RESP;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign bus_ready  = (state_q == ST_RESP);
   assign bus_rdata  = bus_ready ? rdata_q : '0;
   assign bus_err    = bus_ready & err_q;
   assign slot_valid = (state_q == ST_SLOT);
   assign slot_write = wr_q;
   assign slot_addr  = addr_q;
   assign slot_wdata = wdata_q;

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready); // R9
   AST_LOCAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && bus_valid && (dec_bad || !dec_slot)) |=> bus_ready); // R9
   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && !slot_ready) |=> (slot_valid && $stable(slot_addr) && $stable(slot_wdata))); // R8
   AST_SLOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_ready) |=> (bus_ready && !slot_valid)); // R8
   AST_BAD_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && bus_valid && dec_bad) |=> (!slot_valid && bus_err)); // R10

endmodule

// File: rtl/sd_vendor_regbank.sv
module sd_vendor_regbank
   import sdvb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned SLOT_BASE  = 'h200,
   parameter int unsigned VEND_WORDS = 128,
   parameter word_t       INFO_RESET = 32'h0001_0000,
   parameter int unsigned INFO_OFS   = 'h00,
   parameter int unsigned PHY_OFS    = 'h10,
   parameter int unsigned TUNE_OFS   = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_ready,
   output logic              bus_err,
   output logic              slot_valid,
   output logic              slot_write,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [31:0]       slot_wdata,
   input  logic [31:0]       slot_rdata,
   input  logic              slot_ready,
   output logic              slot_rst,
   input  logic              slot_irq,
   output logic              irq
);

   localparam int unsigned VIDX_W = (VEND_WORDS > 1) ? $clog2(VEND_WORDS) : 1;

   generate
      if (SLOT_BASE != VEND_WORDS * 4) begin : g_bad_base
         $error("sd_vendor_regbank: vendor storage must end at the slot base");
      end
      if ((1 << ADDR_W) <= SLOT_BASE) begin : g_bad_window
         $error("sd_vendor_regbank: window leaves no room for the slot");
      end
      if ((INFO_OFS % 4) != 0 || (PHY_OFS % 4) != 0 || (TUNE_OFS % 4) != 0) begin : g_bad_align
         $error("sd_vendor_regbank: register offsets must be word aligned");
      end
   endgenerate

   logic              dec_bad;
   logic              dec_slot;
   logic [VIDX_W-1:0] dec_idx;
   logic [ADDR_W-1:0] dec_slot_ofs;
   word_t             bank_rdata;
   logic              bank_we;

   sdvb_decode #(
      .ADDR_W    (ADDR_W),
      .SLOT_BASE (SLOT_BASE),
      .VIDX_W    (VIDX_W)
   ) i_decode (
      .addr     (bus_addr),
      .size     (bus_size),
      .is_bad   (dec_bad),
      .is_slot  (dec_slot),
      .word_idx (dec_idx),
      .slot_ofs (dec_slot_ofs)
   );

   sdvb_vendor_bank #(
      .VEND_WORDS (VEND_WORDS),
      .VIDX_W     (VIDX_W),
      .INFO_RESET (INFO_RESET),
      .INFO_IDX   (INFO_OFS / 4),
      .PHY_IDX    (PHY_OFS / 4),
      .TUNE_IDX   (TUNE_OFS / 4)
   ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bank_we),
      .widx      (dec_idx),
      .wdata     (bus_wdata),
      .ridx      (dec_idx),
      .rdata     (bank_rdata),
      .swr_pulse (slot_rst)
   );

   sdvb_bus_fsm #(
      .ADDR_W (ADDR_W)
   ) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_valid    (bus_valid),
      .bus_write    (bus_write),
      .bus_wdata    (bus_wdata),
      .dec_bad      (dec_bad),
      .dec_slot     (dec_slot),
      .dec_slot_ofs (dec_slot_ofs),
      .bank_rdata   (bank_rdata),
      .bank_we      (bank_we),
      .bus_ready    (bus_ready),
      .bus_rdata    (bus_rdata),
      .bus_err      (bus_err),
      .slot_valid   (slot_valid),
      .slot_write   (slot_write),
      .slot_addr    (slot_addr),
      .slot_wdata   (slot_wdata),
      .slot_rdata   (slot_rdata),
      .slot_ready   (slot_ready)
   );

   // Interrupt passes straight through (R11).
   assign irq = slot_irq;

   AST_RST_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      slot_rst |-> (bus_ready && !bus_err)); // R5
   AST_ERR_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_ready && bus_rdata == '0)); // R10

endmodule

// File: tb/test_sd_vendor_regbank.sv
`timescale 1ns/1ps
module test_sd_vendor_regbank;

   typedef struct {
      logic [31:0] rdata;
      logic        err;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_size = 2'd2;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        bus_err;
   logic        slot_valid;
   logic        slot_write;
   logic [11:0] slot_addr;
   logic [31:0] slot_wdata;
   logic [31:0] slot_rdata;
   logic        slot_ready;
   logic        slot_rst;
   logic        slot_irq = 1'b0;
   logic        irq;

   int errors = 0;
   int checks = 0;
   int slot_dly = 0;
   int wait_cnt = 0;
   int slot_cnt = 0;
   int rst_cnt  = 0;
   logic [11:0] last_addr = '0;
   logic [31:0] last_data = '0;
   logic        last_wr   = 1'b0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   sd_vendor_regbank i_sd_vendor_regbank (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
      .slot_valid(slot_valid), .slot_write(slot_write), .slot_addr(slot_addr),
      .slot_wdata(slot_wdata), .slot_rdata(slot_rdata), .slot_ready(slot_ready),
      .slot_rst(slot_rst), .slot_irq(slot_irq), .irq(irq)
   );

   // Slot-side responder with programmable wait.
   assign slot_ready = slot_valid && (wait_cnt == slot_dly);
   assign slot_rdata = 32'hC0DE_0000 | {20'h0, slot_addr};

   always @(posedge clk) begin
      if (!slot_valid) wait_cnt <= 0;
      else if (!slot_ready) wait_cnt <= wait_cnt + 1;
      if (slot_valid && slot_ready) begin
         slot_cnt  <= slot_cnt + 1;
         last_addr <= slot_addr;
         last_data <= slot_wdata;
         last_wr   <= slot_write;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every response.
   always @(negedge clk) begin
      if (rst_n && bus_ready) begin
         if (slot_rst) rst_cnt++;
         if (sb_q.size() == 0) begin
            check(1'b0, "R9 unexpected response", {31'h0, bus_ready}, 32'h0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(bus_rdata == e.rdata, {e.tag, " rdata"}, bus_rdata, e.rdata);
            check(bus_err == e.err, {e.tag, " err"}, {31'h0, bus_err}, {31'h0, e.err});
         end
      end else if (rst_n && slot_rst) begin
         rst_cnt++;
      end
   end

   // Driver: pushes the expectation, runs the handshake, checks the latency.
   task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [31:0] exp_rd,
                         input bit exp_err, input int exp_lat, input string tag);
      exp_t e;
      int lat;
      e.rdata = exp_rd; e.err = exp_err; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!bus_ready && lat < 100);
      bus_valid = 1'b0;
      check(lat == exp_lat, {tag, " latency (R8/R9)"}, 32'(lat), 32'(exp_lat));
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
      access(1'b1, a, 2'd2, d, 32'h0, 1'b0, (a >= 12'h200) ? 2 + slot_dly : 1, tag);
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      access(1'b0, a, 2'd2, 32'h0, exp, 1'b0, (a >= 12'h200) ? 2 + slot_dly : 1, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n_slot;
      int n_rst;
      repeat (4) @(negedge clk);
      check(bus_ready == 1'b0 && slot_valid == 1'b0 && slot_rst == 1'b0, "R1 idle outputs in reset",
            {29'h0, bus_ready, slot_valid, slot_rst}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset values
      rd(12'h000, 32'h0001_0000, "R1 info reset");
      rd(12'h010, 32'h0, "R1 phy reset");
      rd(12'h018, 32'h0, "R1 tune reset");
      rd(12'h1FC, 32'h0, "R1 top word reset");

      // R2 PHY acknowledge echo
      wr(12'h010, 32'h0100_0000, "R2 write req");
      rd(12'h010, 32'h0500_0000, "R2 write req ack");
      wr(12'h010, 32'h0200_1234, "R2 read req");
      rd(12'h010, 32'h0600_1234, "R2 read req ack");
      wr(12'h010, 32'h0400_00FF, "R2 no req");
      rd(12'h010, 32'h0000_00FF, "R2 ack dropped");
      wr(12'h010, 32'h0300_0000, "R2 both req");
      rd(12'h010, 32'h0700_0000, "R2 both req ack");

      // R3 tune bit cleared
      wr(12'h018, 32'hFFFF_FFFF, "R3 all ones");
      rd(12'h018, 32'hFFFF_7FFF, "R3 tune cleared");
      wr(12'h018, 32'h0000_8001, "R3 tune only");
      rd(12'h018, 32'h0000_0001, "R3 other bit kept");

      // R4 plain storage
      wr(12'h004, 32'hDEAD_BEEF, "R4 low word");
      wr(12'h1FC, 32'h1234_5678, "R4 top word");
      rd(12'h004, 32'hDEAD_BEEF, "R4 low readback");
      rd(12'h1FC, 32'h1234_5678, "R4 top readback");

      // R6 info write without reset bit
      n_rst = rst_cnt;
      wr(12'h000, 32'hFFFF_FFFE, "R6 info write");
      rd(12'h000, 32'h0001_0000, "R6 info unchanged");
      rd(12'h004, 32'hDEAD_BEEF, "R6 other kept");
      check(rst_cnt == n_rst, "R6 no slot reset", 32'(rst_cnt), 32'(n_rst));

      // R7/R8 forwarding
      slot_dly = 0;
      n_slot = slot_cnt;
      wr(12'h200, 32'hA5A5_0001, "R7 fwd write");
      check(slot_cnt == n_slot + 1 && last_addr == 12'h000 && last_wr == 1'b1,
            "R7 fwd write addr", {20'h0, last_addr}, 32'h0);
      check(last_data == 32'hA5A5_0001, "R7 fwd write data", last_data, 32'hA5A5_0001);
      rd(12'h3FC, 32'hC0DE_01FC, "R7 fwd read");
      check(last_addr == 12'h1FC && last_wr == 1'b0, "R7 fwd read addr", {20'h0, last_addr}, 32'h1FC);
      slot_dly = 3;
      rd(12'hFFC, 32'hC0DE_0DFC, "R8 fwd read wait 3");
      wr(12'h800, 32'h0BAD_F00D, "R8 fwd write wait 3");
      check(last_addr == 12'h600 && last_data == 32'h0BAD_F00D, "R8 fwd waited write",
            {20'h0, last_addr}, 32'h600);
      slot_dly = 0;

      // R10 rejected accesses
      n_slot = slot_cnt;
      access(1'b0, 12'h006, 2'd2, 32'h0, 32'h0, 1'b1, 1, "R10 misaligned read");
      access(1'b1, 12'h202, 2'd2, 32'h1111_1111, 32'h0, 1'b1, 1, "R10 misaligned slot write");
      access(1'b1, 12'h004, 2'd1, 32'h2222_2222, 32'h0, 1'b1, 1, "R10 narrow write");
      access(1'b0, 12'h004, 2'd3, 32'h0, 32'h0, 1'b1, 1, "R10 wide read");
      check(slot_cnt == n_slot, "R10 not forwarded", 32'(slot_cnt), 32'(n_slot));
      rd(12'h004, 32'hDEAD_BEEF, "R10 no store");

      // R5 software reset
      n_rst = rst_cnt;
      wr(12'h000, 32'h0000_0001, "R5 reset write");
      rd(12'h004, 32'h0, "R5 low word cleared");
      check(rst_cnt == n_rst + 1, "R5 single slot reset pulse", 32'(rst_cnt), 32'(n_rst + 1));
      rd(12'h010, 32'h0, "R5 phy cleared");
      rd(12'h018, 32'h0, "R5 tune cleared");
      rd(12'h1FC, 32'h0, "R5 top word cleared");
      rd(12'h000, 32'h0001_0000, "R5 info after reset");

      // R11 interrupt pass-through
      @(negedge clk); slot_irq = 1'b1; #1;
      check(irq == 1'b1, "R11 irq high", {31'h0, irq}, 32'h1);
      @(negedge clk); slot_irq = 1'b0; #1;
      check(irq == 1'b0, "R11 irq low", {31'h0, irq}, 32'h0);

      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R9 all responses seen", 32'(sb_q.size()), 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule